// File: doc/BRIEF.md
# Reference-Counted Physical Register Allocator

This block hands out physical registers to the rename stage of an out-of-order core that supports move elimination. Each physical register has its own small use counter. Several architectural names may map onto one physical register, so the counter tracks how many live mappings point at it.

A fresh allocation raises a register's count from zero to one. An eliminated move adds one more mapping to a register that is already live. A commit-time release removes one mapping. A register becomes free again only when its count reaches zero. The free pool is the set of registers whose count is zero.

The allocation port grants zero, one or two registers per cycle, always the lowest-numbered free ones. A redirect cycle suppresses the grant. If a counter would go below zero or above its maximum, a sticky error flag is raised.

Top module: `preg_refcount_alloc`

## Requirements
- R1: After reset, registers 0 to NUM_ARCH-1 (0..31 by default) hold a count of one and all other registers hold zero. The free count then equals NUM_PREG-NUM_ARCH, and the error flag is low.
- R2: When `alloc_num_i` (0, 1 or 2) is non-zero, no larger than the free count, and `flush_i` is low, `alloc_grant_o` is high in the same cycle. `alloc_preg0_o` is the lowest-numbered free register and `alloc_preg1_o` is the next lowest. Each granted register holds a count of one from the next cycle on.
- R3: When `alloc_num_i` exceeds the free count, `alloc_stall_o` is high, `alloc_grant_o` is low and no register is taken.
- R4: While `flush_i` is high, `alloc_grant_o` is low and no register is taken, whatever `alloc_num_i` is.
- R5: Each valid increment port adds one to the count of its register. Two ports naming the same register add two.
- R6: Each valid release port subtracts one from the count of its register.
- R7: A register returns to the free pool, visible in `free_cnt_o` and the allocation picks on the next cycle, only when its count reaches zero. A register whose count stays above zero is never offered.
- R8: All allocations, increments and releases that name the same register in one cycle are combined into a single net change.
- R9: A net change that would take a count below zero leaves the count at zero and raises `err_o`. A net change that would take a count above 2^CNT_W-1 saturates the count there and raises `err_o`.
- R10: `err_o` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_num_i | input | 2 | Number of registers requested this cycle (0..2) |
| flush_i | input | 1 | Redirect; suppresses the allocation this cycle |
| inc_vld_i | input | INC_N | Move-elimination increment valid, one bit per port |
| inc_preg_i | input | INC_N*PW | Increment register indices, port k at bits [k*PW +: PW] |
| dec_vld_i | input | DEC_N | Release valid, one bit per port |
| dec_preg_i | input | DEC_N*PW | Release register indices, port k at bits [k*PW +: PW] |
| alloc_grant_o | output | 1 | Request accepted this cycle |
| alloc_stall_o | output | 1 | Request larger than the free pool |
| alloc_preg0_o | output | PW | Lowest-numbered free register |
| alloc_preg1_o | output | PW | Second lowest-numbered free register |
| free_cnt_o | output | PW+1 | Number of registers with a count of zero |
| err_o | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench targets the cycle in which an allocation and a release hit the same register. A design that applied only one of the two would either leak the register or hand it out while it is still live. It also drives two eliminated moves onto one register in a single cycle, which a design counting ports rather than adding them would undercount, so the register would be freed early. A register is walked from a count of three down to zero to show that it is offered only after the last release. The pool is drained to a single entry to confirm that a two-register request stalls rather than granting half. Finally, the bench forces both saturation and underflow and confirms that the error flag survives later clean cycles.

// File: rtl/preg_refcount_alloc.sv
module preg_refcount_alloc #(
  parameter int NUM_PREG = 64,
  parameter int NUM_ARCH = 32,
  parameter int CNT_W    = 3,
  parameter int INC_N    = 2,
  parameter int DEC_N    = 2,
  localparam int PW      = $clog2(NUM_PREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            alloc_num_i,
  input  logic                  flush_i,
  input  logic [INC_N-1:0]      inc_vld_i,
  input  logic [INC_N*PW-1:0]   inc_preg_i,
  input  logic [DEC_N-1:0]      dec_vld_i,
  input  logic [DEC_N*PW-1:0]   dec_preg_i,
  output logic                  alloc_grant_o,
  output logic                  alloc_stall_o,
  output logic [PW-1:0]         alloc_preg0_o,
  output logic [PW-1:0]         alloc_preg1_o,
  output logic [PW:0]           free_cnt_o,
  output logic                  err_o
);
  localparam int SW = CNT_W + 3;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt   [NUM_PREG];
  logic [NUM_PREG-1:0] free_v, under_v, over_v;
  logic [PW-1:0] p0, p1;
  logic f0, f1;
  logic take0, take1;

  always_comb begin
    p0 = '0; p1 = '0; f0 = 1'b0; f1 = 1'b0;
    for (int i = 0; i < NUM_PREG; i++) begin
      if (free_v[i]) begin
        if (!f0) begin
          p0 = PW'(i); f0 = 1'b1;
        end else if (!f1) begin
          p1 = PW'(i); f1 = 1'b1;
        end
      end
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < NUM_PREG; i++) free_cnt_o = free_cnt_o + (PW+1)'(free_v[i]);
  end

  assign alloc_stall_o = (PW+1)'(alloc_num_i) > free_cnt_o;
  assign alloc_grant_o = (alloc_num_i != 2'd0) && !alloc_stall_o && !flush_i;
  assign take0 = alloc_grant_o;
  assign take1 = alloc_grant_o && (alloc_num_i == 2'd2);
  assign alloc_preg0_o = p0;
  assign alloc_preg1_o = p1;

  for (genvar g = 0; g < NUM_PREG; g++) begin : g_reg
    logic [SW-1:0] add, sub, sum;
    logic [CNT_W-1:0] nxt;

    assign free_v[g] = (cnt[g] == '0);

    always_comb begin
      add = '0;
      sub = '0;
      if (take0 && p0 == PW'(g)) add = add + SW'(1);
      if (take1 && p1 == PW'(g)) add = add + SW'(1);
      for (int k = 0; k < INC_N; k++)
        if (inc_vld_i[k] && inc_preg_i[k*PW +: PW] == PW'(g)) add = add + SW'(1);
      for (int k = 0; k < DEC_N; k++)
        if (dec_vld_i[k] && dec_preg_i[k*PW +: PW] == PW'(g)) sub = sub + SW'(1);
      sum = SW'(cnt[g]) + add;
      under_v[g] = 1'b0;
      over_v[g]  = 1'b0;
      if (sum < sub) begin
        under_v[g] = 1'b1;
        nxt = '0;
      end else if (sum - sub > SW'(CMAX)) begin
        over_v[g] = 1'b1;
        nxt = CMAX;
      end else begin
        nxt = CNT_W'(sum - sub);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= (g < NUM_ARCH) ? CNT_W'(1) : '0;
      else        cnt[g] <= nxt;
    end

    p_take_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take0 && p0 == PW'(g)) |-> cnt[g] == '0);
    p_keep_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] != '0 && sub == '0) |=> cnt[g] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_o | (|under_v) | (|over_v);
  end

  p_pair_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant_o && alloc_num_i == 2'd2) |-> alloc_preg0_o != alloc_preg1_o);
  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall_o |-> !alloc_grant_o);
  p_flush_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !alloc_grant_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  p_pool_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt_o <= (PW+1)'(NUM_PREG));
endmodule

// File: tb/tb_preg_refcount_alloc.sv
`timescale 1ns/1ps
module tb_preg_refcount_alloc;
  localparam int NP = 64, NA = 32, CW = 3, PW = 6;
  localparam int CMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] alloc_num_i = '0;
  logic flush_i = 1'b0;
  logic [1:0] inc_vld_i = '0, dec_vld_i = '0;
  logic [2*PW-1:0] inc_preg_i = '0, dec_preg_i = '0;
  logic alloc_grant_o, alloc_stall_o, err_o;
  logic [PW-1:0] alloc_preg0_o, alloc_preg1_o;
  logic [PW:0] free_cnt_o;

  int mc [NP];
  bit merr;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  preg_refcount_alloc #(.NUM_PREG(NP), .NUM_ARCH(NA), .CNT_W(CW), .INC_N(2), .DEC_N(2)) dut (
    .clk, .rst_n, .alloc_num_i, .flush_i, .inc_vld_i, .inc_preg_i, .dec_vld_i, .dec_preg_i,
    .alloc_grant_o, .alloc_stall_o, .alloc_preg0_o, .alloc_preg1_o, .free_cnt_o, .err_o);

  function automatic void cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  function automatic void pool(output int fc, output int q0, output int q1);
    int f[$];
    foreach (mc[i]) if (mc[i] == 0) f.push_back(i);
    fc = f.size();
    q0 = (fc > 0) ? f[0] : 0;
    q1 = (fc > 1) ? f[1] : 0;
  endfunction

  function automatic void mreset();
    foreach (mc[i]) mc[i] = (i < NA) ? 1 : 0;
    merr = 1'b0;
  endfunction

  task automatic cycle(string tag);
    int fc, q0, q1, nm;
    bit st, gr;
    int d [NP];
    #1;
    pool(fc, q0, q1);
    nm = int'(alloc_num_i);
    st = nm > fc;
    gr = (nm != 0) && !st && !flush_i;
    cmp(tag, "free_cnt", int'(free_cnt_o), fc);
    cmp(tag, "stall", int'(alloc_stall_o), int'(st));
    cmp(tag, "grant", int'(alloc_grant_o), int'(gr));
    cmp(tag, "err", int'(err_o), int'(merr));
    if (fc >= 1) cmp(tag, "preg0", int'(alloc_preg0_o), q0);
    if (fc >= 2) cmp(tag, "preg1", int'(alloc_preg1_o), q1);
    foreach (d[i]) d[i] = 0;
    if (gr) begin
      d[q0]++;
      if (nm == 2) d[q1]++;
    end
    for (int k = 0; k < 2; k++) begin
      if (inc_vld_i[k]) d[inc_preg_i[k*PW +: PW]]++;
      if (dec_vld_i[k]) d[dec_preg_i[k*PW +: PW]]--;
    end
    @(posedge clk);
    foreach (mc[i]) begin
      int v;
      v = mc[i] + d[i];
      if (v < 0) begin v = 0; merr = 1'b1; end
      if (v > CMAX) begin v = CMAX; merr = 1'b1; end
      mc[i] = v;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_num_i = '0; flush_i = 1'b0; inc_vld_i = '0; dec_vld_i = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    mreset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic inc2(int a, bit va, int b, bit vb);
    inc_vld_i = {vb, va};
    inc_preg_i = {PW'(b), PW'(a)};
  endtask

  task automatic dec2(int a, bit va, int b, bit vb);
    dec_vld_i = {vb, va};
    dec_preg_i = {PW'(b), PW'(a)};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    cycle("R1 reset state");
    cmp("R1 free count", "free_cnt", int'(free_cnt_o), NP - NA);
    cmp("R1 lowest free", "preg0", int'(alloc_preg0_o), NA);

    alloc_num_i = 2'd2; cycle("R2 two-grant");
    alloc_num_i = 2'd1; cycle("R2 one-grant");
    idle(); cycle("R2 after grant");
    cmp("R2 next pick", "preg0", int'(alloc_preg0_o), 35);

    inc2(33, 1, 33, 1); cycle("R5 double increment");
    idle(); dec2(33, 1, 33, 1); cycle("R6 double release");
    idle(); cycle("R7 still live");
    cmp("R7 33 not offered", "preg0", int'(alloc_preg0_o), 35);
    dec2(33, 1, 0, 0); cycle("R7 last release");
    idle(); cycle("R7 freed");
    cmp("R7 33 offered", "preg0", int'(alloc_preg0_o), 33);

    inc2(5, 1, 0, 0); dec2(5, 1, 0, 0); cycle("R8 inc+dec same reg");
    idle(); dec2(5, 1, 0, 0); cycle("R8 count still one");
    idle(); cycle("R8 5 freed");
    cmp("R8 5 offered", "preg0", int'(alloc_preg0_o), 5);
    alloc_num_i = 2'd1; dec2(5, 1, 0, 0); cycle("R8 alloc+release same reg");
    idle(); cycle("R8 alloc+release net zero");
    cmp("R8 5 still free", "preg0", int'(alloc_preg0_o), 5);

    alloc_num_i = 2'd2; flush_i = 1'b1; cycle("R4 flush");
    idle(); cycle("R4 nothing taken");

    for (int n = 0; n < 40; n++) begin
      alloc_num_i = (free_cnt_o >= 2) ? 2'd2 : 2'd0;
      cycle("R2 drain");
    end
    idle();
    while (free_cnt_o > 1) begin alloc_num_i = 2'd1; cycle("R2 drain single"); end
    alloc_num_i = 2'd2; cycle("R3 stall two of one");
    cmp("R3 stalled", "stall", int'(alloc_stall_o), 1);
    alloc_num_i = 2'd1; cycle("R3 one of one");
    alloc_num_i = 2'd1; cycle("R3 empty pool");
    idle();

    do_reset();
    for (int n = 0; n < 300; n++) begin
      int a, b, c, e;
      alloc_num_i = 2'($urandom % 3);
      flush_i = ($urandom % 8) == 0;
      a = $urandom % NP; b = $urandom % NP;
      c = $urandom % NP; e = $urandom % NP;
      inc2(a, mc[a] > 0 && mc[a] < 5, b, mc[b] > 0 && mc[b] < 5);
      dec2(c, mc[c] > 0, e, mc[e] > 0 && e != c);
      cycle("R8 random mix");
    end
    idle(); cycle("R9 no error in legal traffic");

    inc2(0, 1, 0, 1);
    repeat (4) cycle("R9 saturate");
    idle(); cycle("R9 overflow flagged");
    cmp("R9 err after overflow", "err", int'(err_o), 1);
    repeat (3) cycle("R10 sticky");
    do_reset(); cycle("R10 reset clears");
    dec2(40, 1, 0, 0); cycle("R9 underflow");
    idle(); cycle("R9 underflow flagged");
    cmp("R9 err after underflow", "err", int'(err_o), 1);
    cmp("R9 clamp keeps 40 free", "preg0", int'(alloc_preg0_o), 32);
    repeat (3) cycle("R10 sticky after underflow");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule